// File: doc/BRIEF.md
# Daisy-Chain SPI Host Sequencer

This block is the host end of an SPI link whose devices are chained output to input, so the whole chain looks like one long shift register. One start request runs one transaction: chip select falls once, the block sends `FRAME_W * N_DEV` SCLK pulses, and then it raises chip select so that every device acts on its own command at the same moment. The bus runs in mode 0: SCLK idles low, MOSI changes on falling edges, and MISO is sampled on rising edges.

The caller gives one 16-bit command for each chain position. Index 0 is the device wired to the host MOSI pin, and index `N_DEV-1` is the device that drives MISO back to the host. Each command is padded at the front with zero bits up to the frame length. The fields are then sent farthest device first, so each command ends up in the right device once shifting stops. The bits that come back are split into one word per chain position, and the first frame to arrive belongs to the farthest device. To read a device register, the read command goes out in one transaction and the data comes back in the next. A start request taken in the cycle where done pulses begins that next transaction at once.

Top module: `dchain_spi_host`

## Requirements
- R1: While reset is asserted, cs_n_o is 1, and sclk_o, mosi_o, busy_o, done_o and every bit of rx_o are 0.
- R2: Each transaction has exactly FRAME_W*N_DEV rising SCLK edges, all inside one cs_n_o low window. sclk_o is 0 whenever cs_n_o is 1.
- R3: The field for cmd_i[N_DEV-1] goes out first and the field for cmd_i[0] goes out last. Every field is sent MSB first.
- R4: Each field is FRAME_W bits long: FRAME_W-16 zero pad bits followed by the 16 command bits.
- R5: The first FRAME_W bits received, taken MSB first, become rx_o[N_DEV-1]. The next FRAME_W bits become rx_o[N_DEV-2], and so on down to rx_o[0].
- R6: Each SCLK half period lasts div_i clock cycles, with div_i sampled at start and a value of 0 treated as 1. MOSI changes only in a cycle where SCLK is low.
- R7: done_o is a one-cycle pulse in the first cycle with cs_n_o high again. In that same cycle rx_o holds the new words.
- R8: start_i is ignored while busy_o is 1. A start_i seen in the done cycle pulls cs_n_o low in the next cycle.
- R9: rx_o changes only in a cycle where done_o is 1.
- R10: cmd_i is captured at start. Changing it during a transaction does not change the bits that are sent.
- R11: busy_o equals the inverse of cs_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one chain transaction when the block is idle |
| div_i | input | DIV_W | Clock cycles per SCLK half period (0 is treated as 1) |
| cmd_i | input | N_DEV x 16 | Command for each chain position (index 0 is nearest the host MOSI pin) |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle pulse when a transaction has finished |
| rx_o | output | N_DEV x FRAME_W | Received word for each chain position |
| cs_n_o | output | 1 | Chip select, active low, shared by all devices |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the first device in the chain |
| miso_i | input | 1 | Serial data from the last device in the chain |

## Verification
The done pulse that ends one transaction and a new start request can fall in the same cycle. That is exactly how a register read is completed in a second transaction. The bench provokes this by raising start_i in the very cycle it sees done_o. It then expects cs_n_o to be low one cycle later. It also expects rx_o to keep the first transaction's words through the whole second transaction, change only when the second done pulse arrives, and by then hold the second pattern.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int unsigned CMD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } dc_state_e;
endpackage

// File: rtl/dchain_tick.sv
module dchain_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = !clr_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dchain_txframe.sv
module dchain_txframe #(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned CMD_W   = 16,
  localparam int unsigned TOT_W  = FRAME_W * N_DEV
) (
  input  logic [N_DEV-1:0][CMD_W-1:0] cmd_i,
  output logic [TOT_W-1:0]            frame_o
);
  localparam int unsigned PAD_W = FRAME_W - CMD_W;

  // Each chain position gets the same bit slice it will be received in,
  // so the farthest device ends up in the top field and is sent first.
  for (genvar k = 0; k < N_DEV; k++) begin : g_field
    if (PAD_W > 0) begin : g_pad
      assign frame_o[k*FRAME_W + CMD_W +: PAD_W] = '0;
    end
    assign frame_o[k*FRAME_W +: CMD_W] = cmd_i[k];
  end
endmodule

// File: rtl/dchain_shreg.sv
module dchain_shreg #(
  parameter int unsigned TOT_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TOT_W-1:0] load_val_i,
  input  logic             tx_shift_i,
  input  logic             rx_shift_i,
  input  logic             sin_i,
  output logic             sout_o,
  output logic [TOT_W-1:0] rx_q_o
);
  logic [TOT_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_q <= '0;
    else if (load_i)     tx_q <= load_val_i;
    else if (tx_shift_i) tx_q <= {tx_q[TOT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rx_q_o <= '0;
    else if (rx_shift_i) rx_q_o <= {rx_q_o[TOT_W-2:0], sin_i};
  end

  assign sout_o = tx_q[TOT_W-1];
endmodule

// File: rtl/dchain_spi_host.sv
module dchain_spi_host
  import dchain_pkg::*;
#(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned DIV_W   = 8,
  localparam int unsigned TOT_W  = FRAME_W * N_DEV,
  localparam int unsigned CNT_W  = $clog2(TOT_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [DIV_W-1:0]              div_i,
  input  logic [N_DEV-1:0][CMD_W-1:0]   cmd_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [N_DEV-1:0][FRAME_W-1:0] rx_o,
  output logic                          cs_n_o,
  output logic                          sclk_o,
  output logic                          mosi_o,
  input  logic                          miso_i
);
  dc_state_e        state_q;
  logic [CNT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             accept;
  logic             last_bit;
  logic             tx_shift;
  logic             rx_shift;
  logic [TOT_W-1:0] frame;
  logic [TOT_W-1:0] rx_q;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_bit = (bit_q == CNT_W'(TOT_W - 1));
  assign rx_shift = (state_q == ST_LOW) && tick;
  assign tx_shift = (state_q == ST_HIGH) && tick && !last_bit;
  assign busy_o   = (state_q != ST_IDLE);

  dchain_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .div_i  (div_q),
    .tick_o (tick)
  );

  dchain_txframe #(.N_DEV(N_DEV), .FRAME_W(FRAME_W), .CMD_W(CMD_W)) u_txframe (
    .cmd_i   (cmd_i),
    .frame_o (frame)
  );

  dchain_shreg #(.TOT_W(TOT_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (frame),
    .tx_shift_i (tx_shift),
    .rx_shift_i (rx_shift),
    .sin_i      (miso_i),
    .sout_o     (mosi_o),
    .rx_q_o     (rx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      div_q   <= '0;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      done_o  <= 1'b0;
      rx_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          div_q   <= div_i;
          bit_q   <= '0;
          cs_n_o  <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk_o  <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_o <= 1'b0;
          if (last_bit) begin
            state_q <= ST_TRAIL;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_TRAIL: if (tick) begin
          cs_n_o  <= 1'b1;
          done_o  <= 1'b1;
          rx_o    <= rx_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_spi_host_chk.sv
module dchain_spi_host_chk #(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned FRAME_W = 32,
  localparam int unsigned TOT_W  = FRAME_W * N_DEV,
  localparam int unsigned RC_W   = $clog2(TOT_W) + 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cs_n_o,
  input logic                          sclk_o,
  input logic                          mosi_o,
  input logic                          busy_o,
  input logic                          done_o,
  input logic [N_DEV-1:0][FRAME_W-1:0] rx_o
);
  logic            sclk_q;
  logic [RC_W-1:0] rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      rise_q <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o)                 rise_q <= '0;
      else if (sclk_o && !sclk_q) rise_q <= rise_q + 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  assert_clock_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> rise_q == RC_W'(TOT_W));

  assert_mosi_low_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mosi_o) && !cs_n_o && $past(!cs_n_o)) |-> !sclk_o);

  assert_done_on_cs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_n_o));

  assert_cs_rise_gives_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> done_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_o));

  assert_busy_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_n_o);
endmodule

bind dchain_spi_host dchain_spi_host_chk #(.N_DEV(N_DEV), .FRAME_W(FRAME_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_o (cs_n_o),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .rx_o   (rx_o)
);

// File: tb/dchain_spi_host_tb.sv
module dchain_spi_host_tb;
  localparam int N   = 4;
  localparam int FW  = 32;
  localparam int CW  = 16;
  localparam int DW  = 8;
  localparam int TOT = N * FW;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [DW-1:0]   div;
    logic [N*CW-1:0] cmd;
    logic [TOT-1:0]  pat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd1, 64'h1234_ABCD_0F0F_8001, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE},
    '{8'd2, 64'hFFFF_0000_5A5A_A5A5, 128'h8000_0001_7FFF_FFFE_AAAA_5555_0000_FFFF},
    '{8'd3, 64'h0001_8000_C3C3_3C3C, 128'h1111_2222_3333_4444_5555_6666_7777_8888},
    '{8'd5, 64'h4000_0002_9999_6666, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [DW-1:0]      div_i = '0;
  logic [N-1:0][CW-1:0] cmd_i = '0;
  logic               busy_o, done_o, cs_n_o, sclk_o, mosi_o, miso_i;
  logic [N-1:0][FW-1:0] rx_o;

  int errors = 0;
  int checks = 0;
  logic [TOT-1:0] pat_cur = '0;
  logic [TOT-1:0] miso_sh = '0;
  logic [TOT-1:0] cap = '0;
  int rise_cnt = 0;
  int hi_cnt = 0;
  int done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_spi_host #(.N_DEV(N), .FRAME_W(FW), .DIV_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .div_i(div_i), .cmd_i(cmd_i),
    .busy_o(busy_o), .done_o(done_o), .rx_o(rx_o), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  // chain model: presents the far-end stream MSB first, captures MOSI on rising SCLK
  assign miso_i = miso_sh[TOT-1];
  always @(negedge cs_n_o) miso_sh = pat_cur;
  always @(negedge sclk_o) if (!cs_n_o) miso_sh = {miso_sh[TOT-2:0], 1'b0};
  always @(posedge sclk_o) begin
    cap = {cap[TOT-2:0], mosi_o};
    rise_cnt++;
  end
  always @(negedge clk) begin
    if (sclk_o) hi_cnt++;
    if (done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act,
                     input logic [TOT-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] exp_tx(input logic [N*CW-1:0] c);
    logic [TOT-1:0] r = '0;
    for (int k = N - 1; k >= 0; k--) r = {r[TOT-FW-1:0], {(FW-CW){1'b0}}, c[k*CW +: CW]};
    return r;
  endfunction

  task automatic start_txn(input logic [DW-1:0] d, input logic [N*CW-1:0] c,
                           input logic [TOT-1:0] p);
    @(negedge clk);
    div_i = d; cmd_i = c; pat_cur = p;
    cap = '0; rise_cnt = 0; hi_cnt = 0; done_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(1'b0, "R7 done timeout", TOT'(n), '0);
  endtask

  task automatic check_txn(input logic [DW-1:0] d, input logic [N*CW-1:0] c,
                           input logic [TOT-1:0] p);
    int de = (d == 0) ? 1 : int'(d);
    chk(rise_cnt == TOT, "R2 sclk rise count", TOT'(rise_cnt), TOT'(TOT));
    chk(cap == exp_tx(c), "R3 R4 mosi stream", cap, exp_tx(c));
    for (int k = 0; k < N; k++)
      chk(rx_o[k] == p[k*FW +: FW], "R5 rx word by position", TOT'(rx_o[k]), TOT'(p[k*FW +: FW]));
    chk(hi_cnt == de * TOT, "R6 sclk high cycles", TOT'(hi_cnt), TOT'(de * TOT));
    chk(done_o && cs_n_o && !busy_o, "R7 done with cs high", TOT'({done_o, cs_n_o, busy_o}), TOT'(3'b110));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*CW-1:0] cx;
    // reset state
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sclk_o && !mosi_o && !busy_o && !done_o && rx_o == '0,
        "R1 reset outputs", TOT'({cs_n_o, sclk_o, mosi_o, busy_o, done_o}), TOT'(5'b10000));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n_o && !sclk_o && !busy_o, "R2 idle sclk low", TOT'({cs_n_o, sclk_o, busy_o}), TOT'(3'b100));

    // table walk
    for (int v = 0; v < 4; v++) begin
      start_txn(VECS[v].div, VECS[v].cmd, VECS[v].pat);
      chk(busy_o && !cs_n_o, "R11 busy during txn", TOT'({busy_o, cs_n_o}), TOT'(2'b10));
      wait_done();
      check_txn(VECS[v].div, VECS[v].cmd, VECS[v].pat);
      @(negedge clk);
      chk(!done_o, "R7 done one cycle", TOT'(done_o), '0);
    end

    // divider of zero behaves as one
    start_txn(8'd0, VECS[2].cmd, VECS[1].pat);
    wait_done();
    check_txn(8'd0, VECS[2].cmd, VECS[1].pat);

    // start and cmd change during a busy transaction are ignored
    cx = VECS[0].cmd;
    start_txn(8'd1, cx, VECS[3].pat);
    repeat (12) @(negedge clk);
    cmd_i = ~cx; div_i = 8'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(cap == exp_tx(cx), "R10 cmd captured at start", cap, exp_tx(cx));
    chk(rise_cnt == TOT, "R8 start while busy ignored", TOT'(rise_cnt), TOT'(TOT));
    chk(hi_cnt == TOT, "R6 div captured at start", TOT'(hi_cnt), TOT'(TOT));
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && !busy_o, "R8 single done", TOT'(done_cnt), TOT'(1));

    // back-to-back: start in the done cycle
    start_txn(8'd2, VECS[1].cmd, VECS[0].pat);
    wait_done();
    chk(rx_o == VECS[0].pat, "R5 first of pair", rx_o, VECS[0].pat);
    cmd_i = VECS[3].cmd; div_i = 8'd1; pat_cur = VECS[2].pat;
    cap = '0; rise_cnt = 0; hi_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!cs_n_o && busy_o, "R8 start in done cycle", TOT'({cs_n_o, busy_o}), TOT'(2'b01));
    chk(rx_o == VECS[0].pat, "R9 rx held after restart", rx_o, VECS[0].pat);
    repeat (40) @(negedge clk);
    chk(rx_o == VECS[0].pat, "R9 rx held mid txn", rx_o, VECS[0].pat);
    wait_done();
    chk(rx_o == VECS[2].pat, "R9 rx updated at done", rx_o, VECS[2].pat);
    chk(cap == exp_tx(VECS[3].cmd), "R3 second of pair", cap, exp_tx(VECS[3].cmd));
    chk(rise_cnt == TOT, "R2 second of pair count", TOT'(rise_cnt), TOT'(TOT));

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule